// File: doc/BRIEF.md
# Flag-Setting Data-Processing ALU

This block is the arithmetic and logic stage of a 32-bit RISC core's data-processing path. Each cycle it takes two operands that are already resolved: the first from the register file or the pipelined program counter, and the second from the shifter or an immediate rotate. With them come a 4-bit operation code, the current carry flag, the shifter's carry-out, a set-flags bit and the destination register index. It produces the result, a destination write enable, and the next N, Z, C and V condition flags, each with its own write enable.

The operations handled are add, add-with-carry, subtract, compare, test (AND), test-equivalence (XOR), OR, move and move-inverted. Any other operation code is reported as unsupported and has no side effects. All outputs are registered, so a result appears one clock after its inputs are presented.

Top module: `dp_flag_alu`

## Requirements
- R1: The operation code selects the operation: 0x2 subtract, 0x4 add, 0x5 add-with-carry, 0x8 test (AND), 0x9 test-equivalence (XOR), 0xA compare, 0xC OR, 0xD move (result is operand B), 0xF move-inverted (result is NOT operand B).
- R2: For add, the result is A+B modulo 2^32. C is the unsigned carry out of bit 31. V is set when the signed sum falls outside the 32-bit signed range.
- R3: For add-with-carry, the result is A+B+carry_in modulo 2^32. C is set when the full unsigned sum exceeds 0xFFFFFFFF, including 0xFFFFFFFF+0+1. V is set on signed overflow of the full sum.
- R4: For subtract and compare, the result is A−B modulo 2^32. C is set when B ≤ A unsigned, meaning no borrow. V is set when the signed difference falls outside the signed range.
- R5: Subtract, add, add-with-carry, OR, move and move-inverted always assert dest_we. They assert flag enables only when set_flags is 1 and dest_idx is not 15. When that condition fails, all four flag enables are 0.
- R6: Compare, test and test-equivalence never assert dest_we. Compare always enables all four flags. Test and test-equivalence always enable N, Z and C, never V, whatever set_flags and dest_idx are.
- R7: For OR, move, move-inverted, test and test-equivalence, C takes shift_carry and V is never enabled.
- R8: Whenever N or Z is enabled, N equals result bit 31 and Z is 1 exactly when the result is zero.
- R9: Any other operation code asserts unsupported, forces the result to 0 and deasserts dest_we and every flag enable.
- R10: Outputs are registered with one cycle of latency. During reset every output is 0, and a flag value output whose enable is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_a | input | 32 | First operand (register or pipelined PC) |
| op_b | input | 32 | Second operand from the shifter or the immediate rotate |
| opcode | input | 4 | Operation select |
| carry_in | input | 1 | Current C flag |
| shift_carry | input | 1 | Shifter carry-out |
| set_flags | input | 1 | Set-flags bit of the instruction |
| dest_idx | input | 4 | Destination register index |
| result | output | 32 | Operation result |
| dest_we | output | 1 | Destination write enable |
| flag_n | output | 1 | Next N |
| flag_z | output | 1 | Next Z |
| flag_c | output | 1 | Next C |
| flag_v | output | 1 | Next V |
| n_we | output | 1 | N update enable |
| z_we | output | 1 | Z update enable |
| c_we | output | 1 | C update enable |
| v_we | output | 1 | V update enable |
| unsupported | output | 1 | Operation code not handled |

## Verification
Random operands are combined with all sixteen operation codes and with the destination index biased toward 15. This separates the set-flags gating from the always-on flags of compare and test, and it shows the unsupported codes staying silent. Directed operands decide the cases that random values almost never reach. 0x7FFFFFFF+1 separates signed overflow from unsigned carry. 0x80000000−1 separates the subtract overflow formula from the add formula. 0−0 shows that a subtract with no borrow sets C and Z. 0xFFFFFFFF+0 with carry-in 1 shows that the carry from the second addition is kept.

// File: rtl/dpalu_pkg.sv
package dpalu_pkg;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 4;
    localparam int OPC_W  = 4;
    localparam logic [IDX_W-1:0] PC_IDX = 4'hF;

    localparam logic [OPC_W-1:0] OPC_SUB = 4'h2;
    localparam logic [OPC_W-1:0] OPC_ADD = 4'h4;
    localparam logic [OPC_W-1:0] OPC_ADC = 4'h5;
    localparam logic [OPC_W-1:0] OPC_TST = 4'h8;
    localparam logic [OPC_W-1:0] OPC_TEQ = 4'h9;
    localparam logic [OPC_W-1:0] OPC_CMP = 4'hA;
    localparam logic [OPC_W-1:0] OPC_ORR = 4'hC;
    localparam logic [OPC_W-1:0] OPC_MOV = 4'hD;
    localparam logic [OPC_W-1:0] OPC_MVN = 4'hF;

    typedef enum logic [2:0] {
        LSEL_AND, LSEL_XOR, LSEL_OR, LSEL_PASS, LSEL_INV
    } lsel_e;

    typedef struct packed {
        logic  supported;
        logic  is_arith;
        logic  is_sub;
        logic  use_cin;
        logic  is_cmp;
        logic  is_test;
        lsel_e lsel;
    } dec_t;

    // flags / flag_we ordered {N, Z, C, V}
    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              dest_we;
        logic [3:0]        flags;
        logic [3:0]        flag_we;
        logic              unsup;
    } alu_out_t;
endpackage

// File: rtl/dp_decode.sv
module dp_decode
    import dpalu_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    always_comb begin
        dec = '0;
        dec.lsel = LSEL_AND;
        dec.supported = 1'b1;
        unique case (opcode)
            OPC_SUB: begin dec.is_arith = 1'b1; dec.is_sub = 1'b1; end
            OPC_ADD: dec.is_arith = 1'b1;
            OPC_ADC: begin dec.is_arith = 1'b1; dec.use_cin = 1'b1; end
            OPC_CMP: begin dec.is_arith = 1'b1; dec.is_sub = 1'b1; dec.is_cmp = 1'b1; end
            OPC_TST: begin dec.is_test = 1'b1; dec.lsel = LSEL_AND; end
            OPC_TEQ: begin dec.is_test = 1'b1; dec.lsel = LSEL_XOR; end
            OPC_ORR: dec.lsel = LSEL_OR;
            OPC_MOV: dec.lsel = LSEL_PASS;
            OPC_MVN: dec.lsel = LSEL_INV;
            default: dec.supported = 1'b0;
        endcase
    end
endmodule

// File: rtl/dp_addsub.sv
module dp_addsub #(
    parameter int W = dpalu_pkg::DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         use_cin,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   wide;

    always_comb begin
        b_eff = sub ? ~b : b;
        c0    = sub ? 1'b1 : (use_cin & cin);
        wide  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        sum   = wide[W-1:0];
        cout  = wide[W];
        ovf   = ((a[W-1] ^ sum[W-1]) & (b_eff[W-1] ^ sum[W-1]));
    end
endmodule

// File: rtl/dp_logic.sv
module dp_logic
    import dpalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  lsel_e        sel,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (sel)
            LSEL_AND:  res = a & b;
            LSEL_XOR:  res = a ^ b;
            LSEL_OR:   res = a | b;
            LSEL_PASS: res = b;
            LSEL_INV:  res = ~b;
            default:   res = '0;
        endcase
    end
endmodule

// File: rtl/dp_flag_alu.sv
module dp_flag_alu
    import dpalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    input  logic [OPC_W-1:0]  opcode,
    input  logic              carry_in,
    input  logic              shift_carry,
    input  logic              set_flags,
    input  logic [IDX_W-1:0]  dest_idx,
    output logic [DATA_W-1:0] result,
    output logic              dest_we,
    output logic              flag_n,
    output logic              flag_z,
    output logic              flag_c,
    output logic              flag_v,
    output logic              n_we,
    output logic              z_we,
    output logic              c_we,
    output logic              v_we,
    output logic              unsupported
);
    dec_t              dec;
    logic [DATA_W-1:0] arith_res, logic_res, sel_res;
    logic              arith_c, arith_v, gate;
    alu_out_t          out_d, out_q;

    dp_decode u_dec (.opcode(opcode), .dec(dec));

    dp_addsub #(.W(DATA_W)) u_add (
        .a(op_a), .b(op_b), .sub(dec.is_sub), .use_cin(dec.use_cin),
        .cin(carry_in), .sum(arith_res), .cout(arith_c), .ovf(arith_v)
    );

    dp_logic #(.W(DATA_W)) u_log (
        .a(op_a), .b(op_b), .sel(dec.lsel), .res(logic_res)
    );

    always_comb begin
        out_d   = '0;
        gate    = set_flags && (dest_idx != PC_IDX);
        sel_res = dec.is_arith ? arith_res : logic_res;
        if (!dec.supported) begin
            out_d.unsup = 1'b1;
        end else begin
            out_d.result = sel_res;
            if (dec.is_arith) begin
                out_d.dest_we = !dec.is_cmp;
                out_d.flag_we = dec.is_cmp ? 4'b1111 : {4{gate}};
                out_d.flags   = {sel_res[DATA_W-1], sel_res == '0, arith_c, arith_v};
            end else begin
                out_d.dest_we = !dec.is_test;
                out_d.flag_we = dec.is_test ? 4'b1110 : {gate, gate, gate, 1'b0};
                out_d.flags   = {sel_res[DATA_W-1], sel_res == '0, shift_carry, 1'b0};
            end
            out_d.flags = out_d.flags & out_d.flag_we;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result      = out_q.result;
    assign dest_we     = out_q.dest_we;
    assign {flag_n, flag_z, flag_c, flag_v} = out_q.flags;
    assign {n_we, z_we, c_we, v_we}         = out_q.flag_we;
    assign unsupported = out_q.unsup;

    // R9: unsupported code has no side effects
    a_r9_unsup_silent: assert property (@(posedge clk) disable iff (!rst_n)
        unsupported |-> (!dest_we && !n_we && !z_we && !c_we && !v_we && result == '0));

    // R5: writing ops targeting index 15 never update flags
    a_r5_pc_no_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(dest_idx) == PC_IDX &&
         ($past(opcode) == OPC_ADD || $past(opcode) == OPC_SUB || $past(opcode) == OPC_ADC ||
          $past(opcode) == OPC_ORR || $past(opcode) == OPC_MOV || $past(opcode) == OPC_MVN))
        |-> (dest_we && !n_we && !z_we && !c_we && !v_we));

    // R6: compare always writes every flag and never the destination
    a_r6_cmp_flags: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(opcode) == OPC_CMP)
        |-> (!dest_we && n_we && z_we && c_we && v_we));

    // R7: test ops take C from the shifter
    a_r7_test_carry: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ($past(opcode) == OPC_TST || $past(opcode) == OPC_TEQ))
        |-> (c_we && !v_we && flag_c == $past(shift_carry)));

    // R8: N and Z track the registered result
    a_r8_nz_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (n_we && z_we) |-> (flag_n == result[DATA_W-1] && flag_z == (result == '0)));
endmodule

// File: tb/dp_flag_alu_test.sv
module dp_flag_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] op_a = '0, op_b = '0;
    logic [3:0]  opcode = '0, dest_idx = '0;
    logic        carry_in = 1'b0, shift_carry = 1'b0, set_flags = 1'b0;
    logic [31:0] result;
    logic        dest_we, flag_n, flag_z, flag_c, flag_v, n_we, z_we, c_we, v_we, unsupported;
    int          n_checks = 0, n_errors = 0;

    always #10 clk = ~clk;

    dp_flag_alu uut (
        .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .opcode(opcode),
        .carry_in(carry_in), .shift_carry(shift_carry), .set_flags(set_flags),
        .dest_idx(dest_idx), .result(result), .dest_we(dest_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
        .n_we(n_we), .z_we(z_we), .c_we(c_we), .v_we(v_we), .unsupported(unsupported)
    );

    // packed {result, dest_we, N,Z,C,V, nwe,zwe,cwe,vwe, unsup}
    function automatic logic [41:0] model(input logic [31:0] a, input logic [31:0] b,
            input logic [3:0] op, input logic cin, input logic sc, input logic s,
            input logic [3:0] rd);
        logic [63:0] u;
        longint      sr;
        logic [31:0] r;
        logic        c, v, we, g, arith;
        logic [3:0]  fwe;
        g = s && (rd != 4'hF);
        c = 1'b0; v = 1'b0; r = '0; we = 1'b0; fwe = '0; arith = 1'b1;
        case (op)
            4'h4, 4'h5: begin
                u  = {32'b0, a} + {32'b0, b} + ((op == 4'h5) ? 64'(cin) : 64'd0);
                sr = longint'($signed(a)) + longint'($signed(b)) + ((op == 4'h5) ? longint'(cin) : 0);
                r = u[31:0]; c = u[32]; v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                we = 1'b1; fwe = {4{g}};
            end
            4'h2, 4'hA: begin
                sr = longint'($signed(a)) - longint'($signed(b));
                r = a - b; c = (b <= a); v = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
                we = (op == 4'h2); fwe = (op == 4'hA) ? 4'hF : {4{g}};
            end
            4'h8, 4'h9, 4'hC, 4'hD, 4'hF: begin
                arith = 1'b0;
                r = (op == 4'h8) ? (a & b) : (op == 4'h9) ? (a ^ b) :
                    (op == 4'hC) ? (a | b) : (op == 4'hD) ? b : ~b;
                c = sc;
                we = !(op == 4'h8 || op == 4'h9);
                fwe = we ? {g, g, g, 1'b0} : 4'b1110;
            end
            default: return {32'b0, 1'b0, 4'b0, 4'b0, 1'b1};
        endcase
        if (!arith) v = 1'b0;
        return {r, we, ({r[31], r == 0, c, v} & fwe), fwe, 1'b0};
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'h4: return "R2";
            4'h5: return "R3";
            4'h2: return "R4";
            4'hA: return "R6";
            4'h8, 4'h9: return "R7";
            4'hC, 4'hD, 4'hF: return "R1";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [41:0] exp);
        logic [41:0] act;
        act = {result, dest_we, flag_n, flag_z, flag_c, flag_v, n_we, z_we, c_we, v_we, unsupported};
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op,
            input logic cin, input logic sc, input logic s, input logic [3:0] rd, input string tag);
        op_a = a; op_b = b; opcode = op; carry_in = cin; shift_carry = sc;
        set_flags = s; dest_idx = rd;
        @(posedge clk); #5;
        check(tag, model(a, b, op, cin, sc, s, rd));
    endtask

    initial begin
        #(20 * 100000);
        n_errors++; n_checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'h1f2e3d4c));
        op_a = 32'hFFFF_FFFF; opcode = 4'h4; set_flags = 1'b1; dest_idx = 4'h1;
        repeat (3) @(posedge clk); #5;
        check("R10 reset", 42'd0);
        rst_n = 1'b1;
        // R2 signed overflow without carry
        apply(32'h7FFF_FFFF, 32'h1, 4'h4, 1'b0, 1'b0, 1'b1, 4'h2, "R2 7fffffff+1");
        apply(32'hFFFF_FFFF, 32'h1, 4'h4, 1'b0, 1'b0, 1'b1, 4'h2, "R2 carry");
        // R4 subtract corners
        apply(32'h8000_0000, 32'h1, 4'h2, 1'b0, 1'b0, 1'b1, 4'h3, "R4 80000000-1");
        apply(32'h0, 32'h0, 4'h2, 1'b0, 1'b0, 1'b1, 4'h3, "R4 0-0");
        apply(32'h0, 32'h1, 4'hA, 1'b0, 1'b0, 1'b0, 4'h3, "R4 borrow cmp");
        // R3 carry from the carry addition
        apply(32'hFFFF_FFFF, 32'h0, 4'h5, 1'b1, 1'b0, 1'b1, 4'h4, "R3 ffffffff+0+1");
        apply(32'h7FFF_FFFF, 32'h0, 4'h5, 1'b1, 1'b0, 1'b1, 4'h4, "R3 ovf via cin");
        // R5 PC destination / S=0 suppress flags
        apply(32'h7FFF_FFFF, 32'h1, 4'h4, 1'b0, 1'b1, 1'b1, 4'hF, "R5 pc dest");
        apply(32'h0, 32'h0, 4'hD, 1'b0, 1'b1, 1'b0, 4'h5, "R5 S=0");
        // R6/R7 test ops with S=0 still update flags
        apply(32'h0F0F_0000, 32'hF0F0_0000, 4'h8, 1'b0, 1'b1, 1'b0, 4'hF, "R7 tst zero");
        apply(32'h8000_0001, 32'h0000_0001, 4'h9, 1'b0, 1'b0, 1'b0, 4'h0, "R6 teq");
        apply(32'h0, 32'h8000_0000, 4'hF, 1'b0, 1'b1, 1'b1, 4'h6, "R8 mvn");
        apply(32'h1234_0000, 32'h0000_5678, 4'hC, 1'b1, 1'b1, 1'b1, 4'h6, "R7 orr");
        // R9 unsupported codes
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'h0, 1'b1, 1'b1, 1'b1, 4'h1, "R9 and");
        apply(32'h5, 32'h3, 4'hB, 1'b1, 1'b1, 1'b1, 4'h1, "R9 cmn");
        for (int i = 0; i < 400; i++) begin
            logic [3:0] op, rd;
            op = 4'($urandom);
            rd = ($urandom % 4 == 0) ? 4'hF : 4'($urandom);
            apply($urandom, ($urandom % 8 == 0) ? 32'h0 : $urandom, op,
                  1'($urandom), 1'($urandom), 1'($urandom), rd, tag_of(op));
        end
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule